// File: doc/BRIEF.md
# Three-Channel Staged Audio Timer

This block supplies three interval timers to a sound coprocessor. A strobe marks each processor cycle. On every strobe, each channel adds a shared step value to its own fractional accumulator. When the accumulator passes the channel's threshold, it toggles a prescaler line. The step value comes from two 2-bit speed selects.

Two global gating inputs can force the prescaler lines low. Each channel counts falling edges of its gated line in an 8-bit compare counter. When that counter matches the channel's target, the channel bumps a 4-bit output counter.

Software programs targets and enables through a simple write port. It collects elapsed intervals by reading an output counter, and each read also clears that counter.

Top module: `audio_timer_unit`

## Requirements
- R1: After reset, all three 4-bit output counters read 0, all targets are 0 and all channels are disabled.
- R2: On every cycle with `cyc_stb` high, each channel adds step = (1 << `clk_sel`) + (2 << `spd_sel`) to its accumulator. When the sum reaches the channel threshold (192 for channels 0 and 1, 24 for channel 2), the threshold is subtracted, the remainder is kept, and the channel's prescaler line toggles.
- R3: The gated line equals the prescaler line only while `run_en` is 1 and `halt` is 0; otherwise it is low. The gated line is re-evaluated every cycle. A compare counter advances once per 1-to-0 transition of its gated line, and this includes a transition caused by closing the gate.
- R4: A channel whose enable bit is 0 never advances its compare or output counter.
- R5: When the incremented compare counter equals the channel's target, the compare counter returns to 0 and the output counter increments modulo 16. Targets are written per channel through `tgt_we`, with `tgt_ch` holding the channel index 0 to 2.
- R6: A target of 0 acts as 256 falling edges per output increment.
- R7: A read (`rd_stb` high, channel index on `rd_ch`) returns the selected output count on `rd_data` in that cycle and clears the count. If an increment falls in the same cycle, the count becomes 1.
- R8: An enable write (`en_we`, with bit i of `en_data` for channel i) that raises a channel's enable from 0 to 1 clears both its compare and output counters. Rewriting a 1 over a 1 leaves them unchanged.
- R9: `cnt_out` carries channel i's output count in bits [4i+3:4i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | One pulse per processor cycle |
| clk_sel | input | 2 | Speed select feeding 1 << clk_sel |
| spd_sel | input | 2 | Speed select feeding 2 << spd_sel |
| run_en | input | 1 | Global gate: lines pass only when 1 |
| halt | input | 1 | Global gate: lines forced low when 1 |
| tgt_we | input | 1 | Target write strobe |
| tgt_ch | input | 2 | Channel index for target write |
| tgt_data | input | 8 | Target value |
| en_we | input | 1 | Enable write strobe |
| en_data | input | 3 | Enable bits, one per channel |
| rd_stb | input | 1 | Read-and-clear strobe |
| rd_ch | input | 2 | Channel index for read |
| rd_data | output | 4 | Selected output count |
| cnt_out | output | 12 | All three output counts |

## Verification
The bench builds the block with its default parameters: thresholds of 192 and 24, with channel 2 as the fast one. With the largest step of 24, the fast channel toggles on every strobe, so a target of 0 (256 edges) fits into about 512 strobes. At the same step, a slow channel toggles every 8 strobes, which lets one run compare both thresholds. A step of 5 does not divide 24, so the fast channel also exposes any loss of the accumulator remainder.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int unsigned SEL_W = 2;
    parameter int unsigned CMP_W = 8;
    parameter int unsigned OUT_W = 4;

    typedef struct packed {
        logic             en;
        logic [CMP_W-1:0] tgt;
        logic [CMP_W-1:0] cmp;
        logic [OUT_W-1:0] out;
    } chan_state_t;
endpackage

// File: rtl/tmr_step_gen.sv
module tmr_step_gen #(
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned STEP_W = 5
) (
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [SEL_W-1:0]  spd_sel,
    output logic [STEP_W-1:0] step
);
    logic [STEP_W-1:0] part_a;
    logic [STEP_W-1:0] part_b;

    always_comb begin
        part_a = STEP_W'(1) << clk_sel;
        part_b = STEP_W'(2) << spd_sel;
        step   = part_a + part_b;
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned THRESH = 192,
    parameter int unsigned STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic [STEP_W-1:0] step,
    output logic              tog
);
    localparam int unsigned ACC_W = $clog2(THRESH + (1 << STEP_W));

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tog;
    } ps_t;

    ps_t              st_q;
    ps_t              st_d;
    logic [ACC_W:0]   sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + (ACC_W + 1)'(step);
        if (cyc_stb) begin
            if (sum >= (ACC_W + 1)'(THRESH)) begin
                st_d.acc = ACC_W'(sum - (ACC_W + 1)'(THRESH));
                st_d.tog = ~st_q.tog;
            end else begin
                st_d.acc = ACC_W'(sum);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tog = st_q.tog;
endmodule

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tog,
    input  logic run_en,
    input  logic halt,
    output logic fall
);
    logic line;
    logic prev_q;
    logic prev_d;

    always_comb begin
        line   = tog & run_en & ~halt;
        prev_d = line;
        fall   = prev_q & ~line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/tmr_chan_cnt.sv
module tmr_chan_cnt
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic             tgt_we,
    input  logic [CMP_W-1:0] tgt_wd,
    input  logic             en_we,
    input  logic             en_wd,
    input  logic             rd_clr,
    output logic [OUT_W-1:0] out_cnt
);
    chan_state_t      st_q;
    chan_state_t      st_d;
    logic [CMP_W-1:0] cmp_inc;
    logic [OUT_W-1:0] out_base;
    logic             hit;

    always_comb begin
        st_d     = st_q;
        cmp_inc  = st_q.cmp + CMP_W'(1);
        hit      = 1'b0;
        out_base = rd_clr ? '0 : st_q.out;

        if (tgt_we) st_d.tgt = tgt_wd;
        if (en_we)  st_d.en  = en_wd;

        if (en_we && en_wd && !st_q.en) begin
            st_d.cmp = '0;
            st_d.out = '0;
        end else begin
            if (fall && st_q.en) begin
                if (cmp_inc == st_q.tgt) begin
                    st_d.cmp = '0;
                    hit      = 1'b1;
                end else begin
                    st_d.cmp = cmp_inc;
                end
            end
            st_d.out = out_base + OUT_W'(hit);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_cnt = st_q.out;
endmodule

// File: rtl/audio_timer_unit.sv
module audio_timer_unit
    import tmr_pkg::*;
#(
    parameter int unsigned NCH      = 3,
    parameter int unsigned THR_SLOW = 192,
    parameter int unsigned THR_FAST = 24,
    parameter int unsigned FAST_CH  = 2,
    localparam int unsigned CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned MAX_SEL = (1 << SEL_W) - 1,
    localparam int unsigned STEP_W  = $clog2((1 << MAX_SEL) + (2 << MAX_SEL) + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_stb,
    input  logic [SEL_W-1:0]     clk_sel,
    input  logic [SEL_W-1:0]     spd_sel,
    input  logic                 run_en,
    input  logic                 halt,
    input  logic                 tgt_we,
    input  logic [CH_W-1:0]      tgt_ch,
    input  logic [CMP_W-1:0]     tgt_data,
    input  logic                 en_we,
    input  logic [NCH-1:0]       en_data,
    input  logic                 rd_stb,
    input  logic [CH_W-1:0]      rd_ch,
    output logic [OUT_W-1:0]     rd_data,
    output logic [NCH*OUT_W-1:0] cnt_out
);
    logic [STEP_W-1:0] step;
    logic [NCH-1:0]    tog;
    logic [NCH-1:0]    fall;

    tmr_step_gen #(.SEL_W(SEL_W), .STEP_W(STEP_W)) u_step (
        .clk_sel (clk_sel),
        .spd_sel (spd_sel),
        .step    (step)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int unsigned THR = (g == FAST_CH) ? THR_FAST : THR_SLOW;

        tmr_prescaler #(.THRESH(THR), .STEP_W(STEP_W)) u_ps (
            .clk     (clk),
            .rst_n   (rst_n),
            .cyc_stb (cyc_stb),
            .step    (step),
            .tog     (tog[g])
        );

        tmr_gate_edge u_ge (
            .clk    (clk),
            .rst_n  (rst_n),
            .tog    (tog[g]),
            .run_en (run_en),
            .halt   (halt),
            .fall   (fall[g])
        );

        tmr_chan_cnt u_cc (
            .clk     (clk),
            .rst_n   (rst_n),
            .fall    (fall[g]),
            .tgt_we  (tgt_we && (tgt_ch == CH_W'(g))),
            .tgt_wd  (tgt_data),
            .en_we   (en_we),
            .en_wd   (en_data[g]),
            .rd_clr  (rd_stb && (rd_ch == CH_W'(g))),
            .out_cnt (cnt_out[g*OUT_W +: OUT_W])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == CH_W'(i)) rd_data = cnt_out[i*OUT_W +: OUT_W];
        end
    end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int unsigned NCH   = 3,
    parameter int unsigned OUT_W = 4,
    parameter int unsigned CH_W  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run_en,
    input logic                 en_we,
    input logic [NCH-1:0]       en_data,
    input logic                 rd_stb,
    input logic [CH_W-1:0]      rd_ch,
    input logic [NCH*OUT_W-1:0] cnt_out
);
    logic [NCH-1:0] en_sh;
    logic [1:0]     age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_sh <= '0;
            age   <= '0;
        end else begin
            if (en_we) en_sh <= en_data;
            if (age != 2'd3) age <= age + 2'd1;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R7
        rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_stb && rd_ch == CH_W'(i)) |=> (cnt_out[i*OUT_W +: OUT_W] <= OUT_W'(1)));
        // R5
        cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age != 2'd0 && !$stable(cnt_out[i*OUT_W +: OUT_W])) |->
            (cnt_out[i*OUT_W +: OUT_W] == OUT_W'($past(cnt_out[i*OUT_W +: OUT_W]) + 1'b1) ||
             cnt_out[i*OUT_W +: OUT_W] <= OUT_W'(1)));
        // R8
        en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_we && en_data[i] && !en_sh[i]) |=> (cnt_out[i*OUT_W +: OUT_W] == '0));
        // R4
        dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_sh[i] && !en_we && !rd_stb) |=> $stable(cnt_out[i*OUT_W +: OUT_W]));
        // R3
        gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2 && !$past(run_en) && !en_we && !rd_stb) |=>
            $stable(cnt_out[i*OUT_W +: OUT_W]));
    end
endmodule

bind audio_timer_unit tmr_unit_chk #(.NCH(NCH), .OUT_W(OUT_W), .CH_W(CH_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .en_we   (en_we),
    .en_data (en_data),
    .rd_stb  (rd_stb),
    .rd_ch   (rd_ch),
    .cnt_out (cnt_out)
);

// File: tb/sim_audio_timer_unit.sv
module sim_audio_timer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_stb = 1'b0;
    logic [1:0]  clk_sel = '0;
    logic [1:0]  spd_sel = '0;
    logic        run_en = 1'b0;
    logic        halt = 1'b0;
    logic        tgt_we = 1'b0;
    logic [1:0]  tgt_ch = '0;
    logic [7:0]  tgt_data = '0;
    logic        en_we = 1'b0;
    logic [2:0]  en_data = '0;
    logic        rd_stb = 1'b0;
    logic [1:0]  rd_ch = '0;
    logic [3:0]  rd_data;
    logic [11:0] cnt_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int       ch;
        logic [3:0] val;
        string    tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    audio_timer_unit u0 (.*);

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // scoreboard monitor for reads
    always @(negedge clk) begin
        if (rst_n && rd_stb) begin
            checks = checks + 1;
            if (exp_q.size() == 0) begin
                errors = errors + 1;
                $display("FAIL R7 unexpected read: actual %0d expected none", rd_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rd_data !== e.val) begin
                    errors = errors + 1;
                    $display("FAIL %s read ch%0d: actual %0d expected %0d", e.tag, e.ch, rd_data, e.val);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc_stb = 0; clk_sel = 0; spd_sel = 0; run_en = 1; halt = 0;
        tgt_we = 0; en_we = 0; rd_stb = 0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic set_tgt(input int ch, input int v);
        tgt_we = 1; tgt_ch = 2'(ch); tgt_data = 8'(v);
        step();
        tgt_we = 0;
    endtask

    task automatic set_en(input logic [2:0] bits);
        en_we = 1; en_data = bits;
        step();
        en_we = 0;
    endtask

    task automatic run(input int k);
        cyc_stb = 1;
        repeat (k) step();
        cyc_stb = 0;
        repeat (3) step();
    endtask

    task automatic rd_expect(input int ch, input int v, input string tag);
        exp_t e;
        e.ch = ch; e.val = 4'(v); e.tag = tag;
        exp_q.push_back(e);
        rd_stb = 1; rd_ch = 2'(ch);
        step();
        rd_stb = 0;
    endtask

    task automatic chk_cnt(input int ch, input int v, input string tag);
        logic [3:0] a;
        a = cnt_out[ch*4 +: 4];
        checks = checks + 1;
        if (a !== 4'(v)) begin
            errors = errors + 1;
            $display("FAIL %s cnt ch%0d: actual %0d expected %0d", tag, ch, a, v);
        end
    endtask

    initial begin
        // R1 reset state
        do_reset();
        chk_cnt(0, 0, "R1"); chk_cnt(1, 0, "R1"); chk_cnt(2, 0, "R1");
        rd_expect(0, 0, "R1");

        // R2 step 3: ch2 (thr 24) toggles every 8 strobes, ch0 (thr 192) every 64
        do_reset();
        set_tgt(2, 1); set_tgt(0, 1); set_en(3'b101);
        run(64);
        chk_cnt(2, 4, "R2"); chk_cnt(0, 0, "R2");

        // R2 remainder carry: step 5, 48 strobes -> 10 toggles -> 5 falls
        do_reset();
        spd_sel = 2'd1;
        set_tgt(2, 1); set_en(3'b100);
        run(48);
        chk_cnt(2, 5, "R2");

        // R5, R4, R9: step 24, distinct targets, ch1 disabled
        do_reset();
        clk_sel = 2'd3; spd_sel = 2'd3;
        set_tgt(2, 3); set_tgt(0, 1); set_tgt(1, 1); set_en(3'b101);
        run(60);
        chk_cnt(2, 10, "R5"); chk_cnt(0, 3, "R9"); chk_cnt(1, 0, "R4");

        // R5 modulo-16 wrap, then R7 read clears
        do_reset();
        clk_sel = 2'd3; spd_sel = 2'd3;
        set_tgt(2, 1); set_en(3'b100);
        run(34);
        chk_cnt(2, 1, "R5");
        rd_expect(2, 1, "R7");
        rd_expect(2, 0, "R7");
        chk_cnt(2, 0, "R7");

        // R6 target 0 acts as 256
        do_reset();
        clk_sel = 2'd3; spd_sel = 2'd3;
        set_tgt(2, 0); set_en(3'b100);
        run(510);
        chk_cnt(2, 0, "R6");
        run(2);
        chk_cnt(2, 1, "R6");

        // R7 read coinciding with increment
        do_reset();
        clk_sel = 2'd3; spd_sel = 2'd3;
        set_tgt(2, 1); set_en(3'b100);
        run(4);
        chk_cnt(2, 2, "R7");
        cyc_stb = 1; step(); step(); cyc_stb = 0;
        rd_expect(2, 2, "R7");
        repeat (3) step();
        chk_cnt(2, 1, "R7");

        // R3 gating
        do_reset();
        clk_sel = 2'd3; spd_sel = 2'd3; run_en = 0;
        set_tgt(2, 1); set_en(3'b100);
        run(40);
        chk_cnt(2, 0, "R3");
        run_en = 1; halt = 1;
        run(40);
        chk_cnt(2, 0, "R3");
        halt = 0;
        run(1);
        chk_cnt(2, 0, "R3");
        halt = 1;
        repeat (3) step();
        chk_cnt(2, 1, "R3");
        halt = 0;

        // R8 enable rising edge resets compare and output counters
        do_reset();
        clk_sel = 2'd3; spd_sel = 2'd3;
        set_tgt(2, 3); set_en(3'b100);
        run(4);
        set_en(3'b000); set_en(3'b100);
        run(2);
        chk_cnt(2, 0, "R8");
        run(4);
        chk_cnt(2, 1, "R8");
        set_en(3'b100);
        chk_cnt(2, 1, "R8");
        set_en(3'b000); set_en(3'b100);
        chk_cnt(2, 0, "R8");

        repeat (3) step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule